// File: doc/BRIEF.md
# Punch Cycle Timing Sequencer

This block generates the timing of one tape-punch mechanism cycle. A command pulse from the host interface starts a cycle. The block then runs through five phases of equal length in order. It fires the coils at the opening of the first phase. It sends an active-low acknowledge pulse back to the interface when the first phase closes. It requests a tape advance when the fourth phase opens. While the cycle runs, it reports itself busy.

The phase length is computed from the system clock frequency and a phase duration in microseconds. By default this is 1700 us per phase, so the advance request comes 5.1 ms after the coils fire. The eight coil-select bits are captured when the cycle starts and appear on the coil outputs only during the fire strobe. A command that arrives while a cycle is running is ignored.

Top module: `punch_timer`

## Requirements
- R1: While rst_n is low and after it is released, the outputs are at rest: busy=0, phase=7 (idle code), punch_stb=0, advance_stb=0, flag_n=1 and coil_out=0.
- R2: When punch_cmd is high at a rising clock edge while idle, the next cycle shows busy=1, phase=0 and punch_stb=1. punch_stb is high for exactly that one cycle.
- R3: coil_out equals the coil_in value sampled at the starting edge during the punch_stb cycle, and is 0 in every other cycle.
- R4: A cycle steps through phase codes 0,1,2,3,4 in order. Each phase lasts PH = CLK_HZ*PHASE_US/1000000 clock cycles.
- R5: flag_n goes low for exactly FLAG_CYCLES cycles, beginning in the first cycle of phase 1 (PH cycles after the punch strobe).
- R6: advance_stb is high for exactly one cycle, the first cycle of phase 3, which is 3*PH cycles after the punch strobe.
- R7: busy is high from the first cycle of phase 0 through the last cycle of phase 4, which is 5*PH cycles in all. It then returns to idle. punch_cmd has no effect while busy, and a command in the first idle cycle starts a new cycle.
- R8: Asserting rst_n low during a cycle aborts it at once. The outputs return to the R1 rest values, and a new command is accepted after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| punch_cmd | input | 1 | Start request for one punch cycle |
| coil_in | input | DW | Coil-select bits to punch |
| coil_out | output | DW | Latched coil selects, driven during the fire strobe only |
| punch_stb | output | 1 | One-cycle fire strobe at the start of phase 0 |
| flag_n | output | 1 | Active-low acknowledge pulse at the end of phase 0 |
| advance_stb | output | 1 | One-cycle tape-advance strobe at the start of phase 3 |
| busy | output | 1 | High while a cycle is in progress |
| phase | output | 3 | Current phase 0..4, or 7 when idle |

## Verification
The assertions check the following on every cycle:
- each strobe is one cycle wide;
- the fire strobe appears only in phase 0 and the advance strobe only in phase 3;
- coil data shows only alongside the fire strobe;
- the phase code never skips or runs backwards;
- a start from idle always produces the fire strobe.

Only the bench scenarios can show the exact phase length, the position and width of the acknowledge pulse, and the 3*PH offset of the advance. They also cover rejection of commands held high through a whole cycle, back-to-back restarts, and abort by reset.

// File: rtl/punch_timer.sv
module punch_timer #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PHASE_US    = 1700,
  parameter int FLAG_CYCLES = 8,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          punch_cmd,
  input  logic [DW-1:0] coil_in,
  output logic [DW-1:0] coil_out,
  output logic          punch_stb,
  output logic          flag_n,
  output logic          advance_stb,
  output logic          busy,
  output logic [2:0]    phase
);

  localparam longint PH_L  = (longint'(CLK_HZ) * longint'(PHASE_US)) / 64'd1000000;
  localparam int     PH    = int'(PH_L);
  localparam int     CW    = (PH > 2) ? $clog2(PH) : 1;
  localparam int     FW    = $clog2(FLAG_CYCLES + 1);
  localparam logic [2:0] IDLE = 3'd7;
  localparam logic [2:0] LAST = 3'd4;
  localparam logic [2:0] PRE_ADV = 3'd2;

  logic [CW-1:0] tick;
  logic [FW-1:0] flag_left;
  logic [2:0]    ph_q;

  wire phase_end = (tick == CW'(PH - 1));
  wire start     = (ph_q == IDLE) && punch_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= IDLE;
      tick        <= '0;
      flag_left   <= '0;
      punch_stb   <= 1'b0;
      advance_stb <= 1'b0;
      coil_out    <= '0;
    end else begin
      punch_stb   <= start;
      coil_out    <= start ? coil_in : '0;
      advance_stb <= 1'b0;
      if (flag_left != '0) flag_left <= flag_left - 1'b1;
      if (start) begin
        ph_q <= 3'd0;
        tick <= '0;
      end else if (ph_q != IDLE) begin
        if (phase_end) begin
          tick <= '0;
          ph_q <= (ph_q == LAST) ? IDLE : ph_q + 3'd1;
          if (ph_q == 3'd0)    flag_left   <= FW'(FLAG_CYCLES);
          if (ph_q == PRE_ADV) advance_stb <= 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign busy   = (ph_q != IDLE);
  assign phase  = ph_q;
  assign flag_n = (flag_left == '0);

endmodule

// File: rtl/punch_timer_chk.sv
module punch_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          punch_cmd,
  input logic [DW-1:0] coil_out,
  input logic          punch_stb,
  input logic          flag_n,
  input logic          advance_stb,
  input logic          busy,
  input logic [2:0]    phase
);

  assert_start_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && punch_cmd) |=> (punch_stb && busy && phase == 3'd0));

  assert_punch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    punch_stb |=> !punch_stb);

  assert_punch_in_t0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    punch_stb |-> (busy && phase == 3'd0));

  assert_coil_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_out != '0) |-> punch_stb);

  assert_phase_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || phase == $past(phase) || phase == $past(phase) + 3'd1));

  assert_flag_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_n |-> (busy && phase == 3'd1));

  assert_adv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance_stb |=> !advance_stb);

  assert_adv_in_t3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance_stb |-> (busy && phase == 3'd3));

  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phase == 3'd7));

  assert_rose_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> punch_stb);

endmodule

bind punch_timer punch_timer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .punch_cmd(punch_cmd), .coil_out(coil_out),
  .punch_stb(punch_stb), .flag_n(flag_n), .advance_stb(advance_stb),
  .busy(busy), .phase(phase)
);

// File: tb/punch_timer_tb_top.sv
`timescale 1ns/1ps
module punch_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 10_000;
  localparam int PHASE_US = 1700;
  localparam int PH = CLK_HZ * PHASE_US / 1000000;
  localparam int FC = 3;
  localparam int NV = 6;
  // {hold_cmd, gap[2:0], data[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 3'd2, 8'hA5}, {1'b0, 3'd0, 8'h00}, {1'b0, 3'd0, 8'hFF},
    {1'b1, 3'd3, 8'h01}, {1'b0, 3'd1, 8'h80}, {1'b0, 3'd0, 8'h5A}
  };

  logic clk = 0, rst_n = 0, punch_cmd = 0;
  logic [7:0] coil_in = 0, coil_out;
  logic punch_stb, flag_n, advance_stb, busy;
  logic [2:0] phase;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  punch_timer #(.CLK_HZ(CLK_HZ), .PHASE_US(PHASE_US), .FLAG_CYCLES(FC), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .punch_cmd(punch_cmd), .coil_in(coil_in),
    .coil_out(coil_out), .punch_stb(punch_stb), .flag_n(flag_n),
    .advance_stb(advance_stb), .busy(busy), .phase(phase)
  );

  wire [14:0] obs = {busy, phase, punch_stb, advance_stb, flag_n, coil_out};

  function automatic logic [14:0] expect_at(int c, logic [7:0] d);
    logic b;
    b = (c < 5*PH);
    return {b, (b ? 3'(c / PH) : 3'd7), (c == 0), (c == 3*PH),
            !(c >= PH && c < PH + FC), ((c == 0) ? d : 8'h00)};
  endfunction

  localparam logic [14:0] REST = {1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 8'h00};

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h (busy,phase,stb,adv,flag_n,coil)", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs, REST);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", obs, REST);

    for (int v = 0; v < NV; v++) begin
      logic hold;
      logic [7:0] d;
      hold = VEC[v][11];
      d = VEC[v][7:0];
      for (int g = 0; g < int'(VEC[v][10:8]); g++) begin
        @(negedge clk);
        chk("R7 idle gap", obs, REST);
      end
      punch_cmd = 1;
      coil_in = d;
      @(negedge clk);
      for (int c = 0; c <= 5*PH; c++) begin
        string tag;
        if (c == 0) tag = "R2 R3 start";
        else if (c >= PH && c < PH + FC) tag = "R5 flag";
        else if (c == 3*PH) tag = "R6 advance";
        else if (c == 5*PH) tag = "R7 end";
        else tag = "R4 phase";
        chk(tag, obs, expect_at(c, d));
        if (c == 0 && !hold) punch_cmd = 0;
        if (hold && c == 2) coil_in = ~d;
        if (hold && c == 5*PH - 2) punch_cmd = 0;
        if (c < 5*PH) @(negedge clk);
      end
    end

    // R8: reset during the flag pulse aborts the cycle
    punch_cmd = 1;
    coil_in = 8'h3C;
    @(negedge clk);
    punch_cmd = 0;
    repeat (PH + 1) @(negedge clk);
    chk("R5 flag before abort", {13'd0, flag_n, 1'b0}, 15'd0);
    rst_n = 0;
    @(negedge clk);
    chk("R8 abort", obs, REST);
    rst_n = 1;
    punch_cmd = 1;
    coil_in = 8'hC3;
    @(negedge clk);
    punch_cmd = 0;
    chk("R8 restart", obs, expect_at(0, 8'hC3));
    repeat (5*PH) @(negedge clk);
    chk("R8 restart completes R7", obs, REST);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule